// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. A frame is a low start bit, then 7 or 8 data bits, then an optional parity bit, then one or two high stop bits. An external bit-rate tick sets the pace, and the line changes only on clock edges where that tick is high. Baud generation, receive logic, queuing and interrupts are left to neighbouring blocks.

An 8-bit settings register sets the frame shape and the enables. It holds the data length, the order in which data bits are sent, the parity policy and the stop length, plus three enables: power, transmit and receive. While the channel is powered and at least one direction is enabled, the shape fields are frozen. A write in that state changes only the enable bits. The host offers a character by pulsing a load strobe while the busy flag is low, and waits for busy to drop before offering the next one.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is 1, busy is 0 and the settings register reads 0x00.
- R2: An accepted load raises busy on the next clock. The line stays 1 until the first tick, and on that tick it goes to the start bit (0). Each later tick moves the line to the next frame bit: data, then parity if present, then stop bits (1). Between ticks the line holds.
- R3: Settings bit 3 selects the data length: 1 gives 8 bits and 0 gives 7 bits. With 7 bits, data bit 7 is not sent.
- R4: Settings bit 4 selects the order: 0 sends the lowest-numbered data bit first, and 1 sends the highest sent bit first.
- R5: Settings bits 7:6 select parity. 00 sends no parity bit and 01 sends a parity bit of 0. 10 sends odd parity and 11 sends even parity, both computed over the data bits actually sent.
- R6: Settings bit 5 selects the stop length: 0 gives one stop bit and 1 gives two.
- R7: Busy stays 1 until the tick that ends the last stop bit, and falls on that tick. A load while busy is ignored and does not disturb the frame in progress.
- R8: While power (bit 0) is 1 and transmit (bit 1) or receive (bit 2) is 1, a write updates only bits 2:0, and bits 7:3 keep their old value.
- R9: From the unlocked state, a single write that sets the enables and the shape fields together is taken in full.
- R10: A load is ignored unless both power and transmit enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_wdata | input | 8 | Settings write value |
| cfg_rdata | output | 8 | Current settings value |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Character load strobe |
| tx_busy | output | 1 | Frame in progress |
| tx_line | output | 1 | Serial output line |

## Verification
A corrupted shift register or bit counter shows on the line at the very next tick. The bench compares the line against a frame it builds itself, bit by bit, for every length, order, parity and stop mix, so a wrong bit is caught in the tick period where it appears. A wrong count makes busy fall one or more ticks early or late, and the check right after the last expected stop bit catches that. A wrong lock decision shows up in the settings value read back one clock after the write.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int MAX_DATA = 8;
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  // Packed from bit 7 down to bit 0.
  typedef struct packed {
    par_mode_e par;
    logic      two_stop;
    logic      msb_first;
    logic      len8;
    logic      rx_en;
    logic      tx_en;
    logic      pwr_en;
  } cfg_t;
endpackage

// File: rtl/uft_cfg_reg.sv
module uft_cfg_reg
  import uft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output cfg_t       cfg_q,
  output logic       locked
);
  cfg_t cfg_d;
  cfg_t wr;

  assign wr     = cfg_t'(wdata);
  assign locked = cfg_q.pwr_en & (cfg_q.tx_en | cfg_q.rx_en);

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.pwr_en = wr.pwr_en;
      cfg_d.tx_en  = wr.tx_en;
      cfg_d.rx_en  = wr.rx_en;
      if (!locked) begin
        cfg_d.len8      = wr.len8;
        cfg_d.msb_first = wr.msb_first;
        cfg_d.two_stop  = wr.two_stop;
        cfg_d.par       = wr.par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R8: shape fields frozen under lock
  a_r8_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (we && locked) |=> $stable(cfg_q[7:3]));

  // R8: enables always writable
  a_r8_enables_follow: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q[2:0] == $past(wdata[2:0])));
endmodule

// File: rtl/uft_frame_build.sv
module uft_frame_build
  import uft_pkg::*;
#(
  parameter int DW = MAX_DATA,
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic [DW-1:0] data,
  input  logic          len8,
  input  logic          msb_first,
  input  logic          two_stop,
  input  par_mode_e     par,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] nbits
);
  logic [DW-1:0] masked;
  logic [DW-1:0] rev_full;
  logic [DW-1:0] rev_short;
  logic [DW-1:0] ordered;
  logic          pbit;

  assign masked = len8 ? data : {1'b0, data[DW-2:0]};

  for (genvar j = 0; j < DW; j++) begin : g_rev
    assign rev_full[j] = data[DW-1-j];
    if (j < DW - 1) begin : g_short
      assign rev_short[j] = data[DW-2-j];
    end else begin : g_pad
      assign rev_short[j] = 1'b0;
    end
  end

  assign ordered = msb_first ? (len8 ? rev_full : rev_short) : masked;

  always_comb begin
    unique case (par)
      PAR_ODD:  pbit = ~^masked;
      PAR_EVEN: pbit = ^masked;
      default:  pbit = 1'b0;
    endcase
  end

  always_comb begin
    int dlen;
    int total;
    dlen     = len8 ? DW : DW - 1;
    frame    = '1;
    frame[0] = 1'b0;
    for (int j = 0; j < DW; j++) begin
      if (j < dlen) frame[1+j] = ordered[j];
    end
    total = 1 + dlen + (two_stop ? 2 : 1);
    if (par != PAR_NONE) begin
      frame[1+dlen] = pbit;
      total         = total + 1;
    end
    nbits = CW'(total);
  end
endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
  import uft_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] nbits_in,
  input  logic          tick,
  output logic          busy,
  output logic          line
);
  logic          busy_q, busy_d;
  logic          wait_q, wait_d;
  logic          line_q, line_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] rem_q, rem_d;

  always_comb begin
    busy_d = busy_q;
    wait_d = wait_q;
    line_d = line_q;
    sh_d   = sh_q;
    rem_d  = rem_q;
    if (start) begin
      busy_d = 1'b1;
      wait_d = 1'b1;
      line_d = 1'b1;
      sh_d   = frame_in;
      rem_d  = nbits_in;
    end else if (busy_q && tick) begin
      if (!wait_q && rem_q == '0) begin
        busy_d = 1'b0;
        line_d = 1'b1;
      end else begin
        wait_d = 1'b0;
        line_d = sh_q[0];
        sh_d   = {1'b1, sh_q[FW-1:1]};
        rem_d  = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      line_q <= 1'b1;
      sh_q   <= '1;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wait_q <= wait_d;
      line_q <= line_d;
      sh_q   <= sh_d;
      rem_q  <= rem_d;
    end
  end

  assign busy = busy_q;
  assign line = line_q;

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q);

  // R2: first tick of a frame drives the start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wait_q && tick) |=> !line_q);

  // R2: line holds between ticks
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(line_q));

  // R7: remaining count stays in range
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= CW'(FW));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       bit_tick,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_busy,
  output logic       tx_line
);
  cfg_t                cfg;
  logic                locked;
  logic                accept;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    nbits;

  uft_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .cfg_q  (cfg),
    .locked (locked)
  );

  uft_frame_build #(.DW(MAX_DATA), .FW(FRAME_W), .CW(CNT_W)) u_build (
    .data      (tx_data),
    .len8      (cfg.len8),
    .msb_first (cfg.msb_first),
    .two_stop  (cfg.two_stop),
    .par       (cfg.par),
    .frame     (frame),
    .nbits     (nbits)
  );

  assign accept = tx_load & ~tx_busy & cfg.pwr_en & cfg.tx_en;

  uft_shifter #(.FW(FRAME_W), .CW(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .frame_in (frame),
    .nbits_in (nbits),
    .tick     (bit_tick),
    .busy     (tx_busy),
    .line     (tx_line)
  );

  assign cfg_rdata = cfg;

  // R10: load with channel disabled leaves the block idle
  a_r10_disabled_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_busy && !(cfg_rdata[0] && cfg_rdata[1])) |=> !tx_busy);

  // R7: busy frame is never restarted by a load
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_load && !bit_tick) |=> (tx_busy && $stable(tx_line)));
endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       bit_tick;
  logic [7:0] tx_data;
  logic       tx_load;
  logic       tx_busy;
  logic       tx_line;

  int n_run  = 0;
  int n_fail = 0;
  bit exp_bits [0:11];
  int exp_n;

  always #4 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bit_tick(bit_tick), .tx_data(tx_data),
    .tx_load(tx_load), .tx_busy(tx_busy), .tx_line(tx_line)
  );

  task automatic check(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic void build_exp(input logic [7:0] d, input logic [7:0] c);
    int  len;
    bit  dbits [0:7];
    bit  par;
    len = c[3] ? 8 : 7;
    par = 1'b0;
    for (int i = 0; i < len; i++) begin
      dbits[i] = c[4] ? d[len-1-i] : d[i];
      par      = par ^ d[i];
    end
    exp_n = 0;
    exp_bits[exp_n++] = 1'b0;
    for (int i = 0; i < len; i++) exp_bits[exp_n++] = dbits[i];
    case (c[7:6])
      2'b01: exp_bits[exp_n++] = 1'b0;
      2'b10: exp_bits[exp_n++] = ~par;
      2'b11: exp_bits[exp_n++] = par;
      default: ;
    endcase
    exp_bits[exp_n++] = 1'b1;
    if (c[5]) exp_bits[exp_n++] = 1'b1;
  endfunction

  task automatic cfg_write(logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(logic [7:0] v);
    cfg_write(8'h00);
    cfg_write(8'h00);
    cfg_write(v);
    check("R9 settings taken in one write", cfg_rdata, v);
  endtask

  task automatic run_frame(string req, logic [7:0] d, logic [7:0] c, bit poke);
    set_cfg(c);
    build_exp(d, c);
    @(negedge clk);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    tx_data = ~d;
    check({req, " R7 busy after load"}, tx_busy, 1);
    check({req, " R2 line idle before first tick"}, tx_line, 1);
    for (int i = 0; i < exp_n; i++) begin
      tick();
      check({req, " R2 frame bit"}, tx_line, exp_bits[i]);
      check({req, " R7 busy in frame"}, tx_busy, 1);
      if (poke && i == 3) begin
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        check({req, " R7 load while busy ignored"}, tx_line, exp_bits[i]);
      end
    end
    tick();
    check({req, " R7 busy falls after last stop"}, tx_busy, 0);
    check({req, " R1 line idle after frame"}, tx_line, 1);
  endtask

  task automatic test_reset();
    check("R1 reset line", tx_line, 1);
    check("R1 reset busy", tx_busy, 0);
    check("R1 reset settings", cfg_rdata, 8'h00);
  endtask

  task automatic test_lock();
    set_cfg(8'h0B);
    cfg_write(8'hF3);
    check("R8 fields kept, enables written", cfg_rdata, 8'h0B);
    cfg_write(8'hF1);
    check("R8 still locked on tx disable", cfg_rdata, 8'h09);
    cfg_write(8'hF1);
    check("R8 unlocked write taken", cfg_rdata, 8'hF1);
    cfg_write(8'h04);
    cfg_write(8'hE0);
    check("R8 power off unlocks", cfg_rdata, 8'hE0);
  endtask

  task automatic test_disabled();
    set_cfg(8'h09);
    @(negedge clk);
    tx_data = 8'h55;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    check("R10 no busy without tx enable", tx_busy, 0);
    tick();
    tick();
    check("R10 line idle without tx enable", tx_line, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; bit_tick = 1'b0;
    tx_data = '0; tx_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_frame("R3 8-bit lsb",       8'hA5, 8'h0B, 0);
    run_frame("R3 7-bit drops b7",  8'hD3, 8'h03, 0);
    run_frame("R4 msb 8-bit",       8'h4E, 8'h1B, 0);
    run_frame("R4 msb 7-bit",       8'hCE, 8'h13, 0);
    run_frame("R5 odd",             8'h5A, 8'h8B, 0);
    run_frame("R5 even",            8'h07, 8'hCB, 0);
    run_frame("R5 zero parity",     8'hFF, 8'h4B, 0);
    run_frame("R5 7-bit even",      8'h81, 8'hC3, 0);
    run_frame("R6 two stop",        8'h3C, 8'h2B, 0);
    run_frame("R6 mixed",           8'h96, 8'hFB, 0);
    run_frame("R7 poke",            8'hC4, 8'h8B, 1);
    test_lock();
    test_disabled();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule